// File: doc/BRIEF.md
# Serial Transmit Engine with Queue Fill Reporting

This block is the sending side of an asynchronous serial port. A host pushes bytes into a queue of 16 entries. The block sends each byte on a single output line as a frame. The frame has a low start bit, then 5 to 8 data bits sent least significant first, then an optional parity bit, then one or two high stop bits. The line rests high between frames. The width of each bit is set by a shared oversampling tick that arrives from a baud-rate generator outside the block. Each bit lasts a fixed number of those ticks.

The host can see how many queue entries are in use at any time. Two status conditions can each raise an interrupt through their own mask: the transmitter having fully drained, and the queue level falling under a programmable threshold (usually half the depth, 8). Further controls pause the sending of frames without losing queued bytes, discard everything not yet sent, and force the line low to signal a break.

Top module: `serial_tx_unit`

## Requirements
- R1: After reset the line is high, the fill count is 0, the drained status is 1 and the interrupt output is 0.
- R2: The fill count equals the number of accepted writes minus the number of frames started, ranging from 0 to 16. It changes by at most one per cycle, except when the queue is cleared.
- R3: A write made while the fill count is 16 is dropped and leaves the fill count at 16.
- R4: Each frame is a 0 start bit followed by the data bits, least significant first. The word-length code 0, 1, 2 or 3 selects 5, 6, 7 or 8 data bits. The line is 1 when idle.
- R5: When parity is enabled, a parity bit follows the data. It makes the count of ones across data and parity even, or odd when odd parity is selected.
- R6: The frame ends with one stop bit of 1, or two when two-stop mode is set. Back-to-back frames follow each other with no extra gap.
- R7: While the transmit enable is low, no new frame starts and queued bytes keep their place. The fill count holds if no write or clear happens. When the enable returns high, the bytes are sent in order.
- R8: While the break control is high, the line is 0 from the next cycle on. The line returns to normal after the control is cleared.
- R9: A pulse on the queue clear sets the fill count to 0 on the next cycle, and the discarded bytes are never sent.
- R10: The drained status is 1 only when the fill count is 0 and no frame is being shifted out.
- R11: The low-level status is 1 exactly when the fill count is less than the threshold input.
- R12: The interrupt output equals, one cycle later, the OR of drained status AND its mask with low-level status AND its mask.
- R13: Each bit lasts OVERSAMPLE baud ticks. With no ticks, the line holds its current bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | Oversampling tick, one pulse per sub-bit period |
| wr_en | input | 1 | Push wr_data into the queue |
| wr_data | input | 8 | Byte to queue |
| tx_enable | input | 1 | Allows new frames to start |
| brk | input | 1 | Forces the line low |
| fifo_clear | input | 1 | Discards all queued bytes |
| word_len | input | 2 | Data-bit count code: 0..3 gives 5..8 bits |
| par_en | input | 1 | Add a parity bit |
| par_odd | input | 1 | Odd parity when set, even otherwise |
| two_stop | input | 1 | Two stop bits when set |
| thresh | input | 5 | Low-level threshold |
| mask_empty | input | 1 | Interrupt mask for drained status |
| mask_low | input | 1 | Interrupt mask for low-level status |
| txd | output | 1 | Serial line |
| fill | output | 5 | Queue entries in use |
| st_empty | output | 1 | Drained status |
| st_low | output | 1 | Low-level status |
| irq | output | 1 | Registered masked interrupt |

## Verification
The bench keeps the queue depth at its default of 16. This makes the full-queue drop and the threshold compare at both ends of the fill range reachable with short bursts. It builds the block with OVERSAMPLE set to 4 and a tick every second clock, so each bit lasts eight clocks. Because frames are short, the bench can decode dozens of random frames in all word lengths, parity kinds and stop counts, and it can still sample each bit at its middle.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int FRAME_MAX = 12;   // start + 8 data + parity + 2 stop

    typedef struct packed {
        logic [1:0] len;       // 0..3 -> 5..8 data bits
        logic       par_en;
        logic       par_odd;
        logic       two_stop;
    } fmt_t;

    typedef struct packed {
        logic [FRAME_MAX-1:0] bits;   // bit 0 leaves first
        logic [3:0]           nbits;
    } frame_t;

    function automatic logic [7:0] data_mask(input logic [1:0] len);
        return 8'hFF >> (2'd3 - len);
    endfunction

    function automatic frame_t build_frame(input logic [7:0] d, input fmt_t f);
        frame_t              fr;
        logic [7:0]          dm;
        logic                p;
        int                  n;
        logic [FRAME_MAX-1:0] v;
        n  = 5 + int'(f.len);
        dm = d & data_mask(f.len);
        p  = f.par_odd ^ (^dm);
        v  = {FRAME_MAX{1'b1}} << (n + 1);
        v  = v | {3'b000, dm, 1'b0};
        if (f.par_en) begin
            v = (v & ~(12'd1 << (n + 1))) | ({11'd0, p} << (n + 1));
        end
        fr.bits  = v;
        fr.nbits = 4'(n + 2 + (f.par_en ? 1 : 0) + (f.two_stop ? 1 : 0));
        return fr;
    endfunction

endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
    parameter int DEPTH  = 16,
    parameter int WIDTH  = 8,
    parameter int FILL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              push_req,
    input  logic [WIDTH-1:0]  din,
    input  logic              pop,
    output logic [WIDTH-1:0]  dout,
    output logic [FILL_W-1:0] count
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             push;

    assign push = push_req && (count != FILL_W'(DEPTH)) && !clear;
    assign dout = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + AW'(1);
            if (pop)  rd_ptr <= rd_ptr + AW'(1);
            case ({push, pop})
                2'b10:   count <= count + FILL_W'(1);
                2'b01:   count <= count - FILL_W'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       baud_tick,
    input  logic       brk,
    input  logic       tx_enable,
    input  logic       avail,
    input  logic       flush,
    input  logic [7:0] head,
    input  fmt_t       fmt,
    output logic       pop,
    output logic       busy,
    output logic       txd
);
    localparam int TW = $clog2(OVERSAMPLE);

    logic [FRAME_MAX-1:0] shreg;
    logic [3:0]           left;
    logic [TW-1:0]        tcnt;
    frame_t               nxt;

    assign nxt = build_frame(head, fmt);
    assign pop = !busy && tx_enable && avail && !flush;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            shreg <= '1;
            left  <= '0;
            tcnt  <= '0;
            txd   <= 1'b1;
        end else begin
            if (pop) begin
                shreg <= nxt.bits;
                left  <= nxt.nbits;
                tcnt  <= '0;
                busy  <= 1'b1;
            end else if (busy && baud_tick) begin
                if (tcnt == TW'(OVERSAMPLE - 1)) begin
                    tcnt  <= '0;
                    shreg <= {1'b1, shreg[FRAME_MAX-1:1]};
                    left  <= left - 4'd1;
                    if (left == 4'd1) busy <= 1'b0;
                end else begin
                    tcnt <= tcnt + TW'(1);
                end
            end
            txd <= brk ? 1'b0 : (busy ? shreg[0] : 1'b1);
        end
    end
endmodule

// File: rtl/sertx_status.sv
module sertx_status #(
    parameter int FILL_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FILL_W-1:0] fill,
    input  logic              busy,
    input  logic [FILL_W-1:0] thresh,
    input  logic              mask_empty,
    input  logic              mask_low,
    output logic              st_empty,
    output logic              st_low,
    output logic              irq
);
    assign st_empty = (fill == '0) && !busy;
    assign st_low   = fill < thresh;

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= (st_empty && mask_empty) || (st_low && mask_low);
    end
endmodule

// File: rtl/serial_tx_unit.sv
module serial_tx_unit
    import sertx_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int OVERSAMPLE = 16,
    parameter int FILL_W     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic              tx_enable,
    input  logic              brk,
    input  logic              fifo_clear,
    input  logic [1:0]        word_len,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    input  logic [FILL_W-1:0] thresh,
    input  logic              mask_empty,
    input  logic              mask_low,
    output logic              txd,
    output logic [FILL_W-1:0] fill,
    output logic              st_empty,
    output logic              st_low,
    output logic              irq
);
    logic       pop, busy;
    logic [7:0] head;
    fmt_t       fmt;

    assign fmt = '{len: word_len, par_en: par_en, par_odd: par_odd, two_stop: two_stop};

    sertx_fifo #(.DEPTH(DEPTH), .WIDTH(8), .FILL_W(FILL_W)) u_fifo (
        .clk(clk), .rst(rst), .clear(fifo_clear), .push_req(wr_en),
        .din(wr_data), .pop(pop), .dout(head), .count(fill)
    );

    sertx_shifter #(.OVERSAMPLE(OVERSAMPLE)) u_shift (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .brk(brk),
        .tx_enable(tx_enable), .avail(fill != '0), .flush(fifo_clear),
        .head(head), .fmt(fmt), .pop(pop), .busy(busy), .txd(txd)
    );

    sertx_status #(.FILL_W(FILL_W)) u_stat (
        .clk(clk), .rst(rst), .fill(fill), .busy(busy), .thresh(thresh),
        .mask_empty(mask_empty), .mask_low(mask_low),
        .st_empty(st_empty), .st_low(st_low), .irq(irq)
    );
endmodule

// File: rtl/sertx_checker.sv
module sertx_checker #(
    parameter int DEPTH  = 16,
    parameter int FILL_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              fifo_clear,
    input logic              tx_enable,
    input logic              brk,
    input logic              txd,
    input logic [FILL_W-1:0] fill,
    input logic              st_empty,
    input logic              st_low,
    input logic              irq,
    input logic              mask_empty,
    input logic              mask_low
);
    a_r2_fill_range: assert property (@(posedge clk) disable iff (rst)
        fill <= FILL_W'(DEPTH));

    a_r2_fill_step: assert property (@(posedge clk) disable iff (rst)
        !fifo_clear |=> (fill == $past(fill) || fill == FILL_W'($past(fill) + FILL_W'(1))
                         || FILL_W'(fill + FILL_W'(1)) == $past(fill)));

    a_r7_hold_fill: assert property (@(posedge clk) disable iff (rst)
        (!tx_enable && !wr_en && !fifo_clear) |=> $stable(fill));

    a_r8_break_low: assert property (@(posedge clk) disable iff (rst)
        brk |=> !txd);

    a_r9_clear_empties: assert property (@(posedge clk) disable iff (rst)
        fifo_clear |=> fill == '0);

    a_r10_empty_fill: assert property (@(posedge clk) disable iff (rst)
        st_empty |-> fill == '0);

    a_r12_irq_follow: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> irq == $past((st_empty && mask_empty) || (st_low && mask_low)));
endmodule

bind serial_tx_unit sertx_checker #(.DEPTH(DEPTH), .FILL_W(FILL_W)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .fifo_clear(fifo_clear),
    .tx_enable(tx_enable), .brk(brk), .txd(txd), .fill(fill),
    .st_empty(st_empty), .st_low(st_low), .irq(irq),
    .mask_empty(mask_empty), .mask_low(mask_low)
);

// File: tb/tb_serial_tx_unit.sv
`timescale 1ns/1ps
module tb_serial_tx_unit;
    localparam int DEPTH = 16;
    localparam int OVS   = 4;
    localparam int BITC  = 2 * OVS;   // clocks per bit (tick every 2nd clock)
    localparam int FW    = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic baud_tick;
    logic wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic tx_enable = 1'b0, brk = 1'b0, fifo_clear = 1'b0;
    logic [1:0] word_len = 2'd3;
    logic par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0;
    logic [FW-1:0] thresh = 5'd8;
    logic mask_empty = 1'b0, mask_low = 1'b0;
    logic txd, st_empty, st_low, irq;
    logic [FW-1:0] fill;

    logic tick_en = 1'b1;
    logic tick_ph = 1'b0;
    assign baud_tick = tick_en && tick_ph;

    always #2 clk = ~clk;   // 250 MHz
    always @(posedge clk) tick_ph <= ~tick_ph;

    serial_tx_unit #(.DEPTH(DEPTH), .OVERSAMPLE(OVS)) dut (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .wr_en(wr_en), .wr_data(wr_data),
        .tx_enable(tx_enable), .brk(brk), .fifo_clear(fifo_clear), .word_len(word_len),
        .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop), .thresh(thresh),
        .mask_empty(mask_empty), .mask_low(mask_low), .txd(txd), .fill(fill),
        .st_empty(st_empty), .st_low(st_low), .irq(irq)
    );

    int checks = 0, fails = 0;
    int frames = 0;
    int mfill = 0;
    logic mon_on = 1'b0;
    logic [7:0] exp_q [$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit exp_par(input logic [7:0] d, input int nb, input bit odd);
        int ones = 0;
        for (int i = 0; i < nb; i++) ones += d[i];
        return odd ? ((ones % 2) == 0) : ((ones % 2) == 1);
    endfunction

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (mfill < DEPTH) begin
            exp_q.push_back(d);
            mfill++;
        end
    endtask

    task automatic wait_empty();
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if (st_empty) break;
        end
        repeat (4) @(negedge clk);
    endtask

    // Frame decoder (R4, R5, R6, R13 through mid-bit sampling)
    initial begin
        forever begin
            @(negedge clk);
            if (mon_on && !txd) begin
                logic [7:0] got;
                logic [7:0] e;
                int nb;
                bit bad;
                got = '0;
                bad = 1'b0;
                nb = 5 + int'(word_len);
                repeat (OVS - 1) @(negedge clk);
                if (txd !== 1'b0) bad = 1'b1;
                for (int i = 0; i < nb; i++) begin
                    repeat (BITC) @(negedge clk);
                    got[i] = txd;
                end
                e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
                mfill = (mfill > 0) ? mfill - 1 : 0;
                chk(!bad && got == (e & (8'hFF >> (8 - nb))), "R4 frame data", int'(got), int'(e));
                if (par_en) begin
                    repeat (BITC) @(negedge clk);
                    chk(txd == exp_par(e, nb, par_odd), "R5 parity bit", int'(txd), int'(exp_par(e, nb, par_odd)));
                end
                repeat (BITC) @(negedge clk);
                chk(txd == 1'b1, "R6 first stop bit", int'(txd), 1);
                if (two_stop) begin
                    repeat (BITC) @(negedge clk);
                    chk(txd == 1'b1, "R6 second stop bit", int'(txd), 1);
                end
                frames++;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int base;
        void'($urandom(32'h5EED1));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(txd == 1'b1, "R1 line idle high", int'(txd), 1);
        chk(fill == 0, "R1 fill zero", int'(fill), 0);
        chk(st_empty == 1'b1, "R1 drained", int'(st_empty), 1);
        chk(irq == 1'b0, "R1 irq low", int'(irq), 0);

        // R2/R3 fill to full with transmit disabled
        for (int i = 0; i < DEPTH; i++) wr(8'(i * 7 + 1));
        chk(fill == 5'd16, "R2 fill after 16 writes", int'(fill), 16);
        chk(st_empty == 1'b0, "R10 not drained with data", int'(st_empty), 0);
        chk(st_low == 1'b0, "R11 16 not below 8", int'(st_low), 0);
        for (int i = 0; i < 3; i++) wr(8'hEE);
        chk(fill == 5'd16, "R3 full drops writes", int'(fill), 16);

        // R11/R12 threshold and irq
        mask_low = 1'b1;
        repeat (2) @(negedge clk);
        chk(irq == 1'b0, "R12 masked low, status 0", int'(irq), 0);
        thresh = 5'd17;
        @(negedge clk);
        chk(st_low == 1'b1, "R11 16 below 17", int'(st_low), 1);
        chk(irq == 1'b1, "R12 irq one cycle after status", int'(irq), 1);
        mask_low = 1'b0;
        thresh = 5'd8;
        repeat (2) @(negedge clk);
        chk(irq == 1'b0, "R12 irq drops when masked", int'(irq), 0);

        // R9 clear discards
        @(negedge clk);
        fifo_clear = 1'b1;
        @(negedge clk);
        fifo_clear = 1'b0;
        exp_q.delete();
        mfill = 0;
        chk(fill == 0, "R9 fill zero after clear", int'(fill), 0);
        chk(st_empty == 1'b1, "R10 drained after clear", int'(st_empty), 1);
        chk(st_low == 1'b1, "R11 0 below 8", int'(st_low), 1);
        tx_enable = 1'b1;
        begin
            bit any_low = 1'b0;
            for (int i = 0; i < 200; i++) begin
                @(negedge clk);
                if (!txd) any_low = 1'b1;
            end
            chk(!any_low, "R9 discarded bytes never sent", int'(any_low), 0);
        end

        // Random formats: R2, R4, R5, R6, R13
        mon_on = 1'b1;
        for (int k = 0; k < 12; k++) begin
            int n;
            tx_enable = 1'b0;
            word_len = 2'($urandom % 4);
            par_en   = 1'($urandom % 2);
            par_odd  = 1'($urandom % 2);
            two_stop = 1'($urandom % 2);
            if (k == 0) begin word_len = 2'd0; par_en = 1'b1; par_odd = 1'b1; two_stop = 1'b1; end
            if (k == 1) begin word_len = 2'd3; par_en = 1'b0; two_stop = 1'b0; end
            n = 1 + int'($urandom % DEPTH);
            if (k == 2) n = DEPTH;
            base = frames;
            for (int i = 0; i < n; i++) wr(8'($urandom));
            chk(fill == 5'(n), "R2 fill equals writes", int'(fill), n);
            tx_enable = 1'b1;
            wait_empty();
            chk(frames - base == n, "R4 frame count", frames - base, n);
            chk(exp_q.size() == 0, "R2 all bytes sent", exp_q.size(), 0);
        end

        // R7 pause keeps queued data
        tx_enable = 1'b0;
        word_len = 2'd3; par_en = 1'b0; two_stop = 1'b0;
        base = frames;
        for (int i = 0; i < 5; i++) wr(8'(8'hA0 + i));
        tx_enable = 1'b1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (fill == 5'd4) break;
        end
        tx_enable = 1'b0;
        repeat (300) @(negedge clk);
        chk(fill == 5'd4, "R7 fill held while disabled", int'(fill), 4);
        chk(frames - base == 1, "R7 only running frame sent", frames - base, 1);
        chk(txd == 1'b1, "R7 line idle while paused", int'(txd), 1);
        tx_enable = 1'b1;
        wait_empty();
        chk(frames - base == 5, "R7 remainder sent on enable", frames - base, 5);

        // R13 frozen ticks hold the line
        mon_on = 1'b0;
        tx_enable = 1'b0;
        wr(8'h00);
        exp_q.delete();
        mfill = 0;
        tx_enable = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!txd) break;
        end
        tick_en = 1'b0;
        begin
            bit moved = 1'b0;
            for (int i = 0; i < 60; i++) begin
                @(negedge clk);
                if (txd) moved = 1'b1;
            end
            chk(!moved, "R13 no ticks holds bit", int'(moved), 0);
        end
        tick_en = 1'b1;
        wait_empty();
        chk(txd == 1'b1, "R13 frame completes after ticks resume", int'(txd), 1);

        // R8 break
        brk = 1'b1;
        repeat (2) @(negedge clk);
        chk(txd == 1'b0, "R8 break forces low", int'(txd), 0);
        repeat (30) @(negedge clk);
        chk(txd == 1'b0, "R8 break held low", int'(txd), 0);
        brk = 1'b0;
        repeat (2) @(negedge clk);
        chk(txd == 1'b1, "R8 line released", int'(txd), 1);

        // R10/R12 drained interrupt
        mask_empty = 1'b1;
        repeat (2) @(negedge clk);
        chk(st_empty == 1'b1, "R10 drained at end", int'(st_empty), 1);
        chk(irq == 1'b1, "R12 drained irq", int'(irq), 1);
        mask_empty = 1'b0;
        repeat (2) @(negedge clk);
        chk(irq == 1'b0, "R12 drained irq masked", int'(irq), 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule